// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block holds a small bank of CAN transmit mailboxes and decides which of them goes on the bus next. Each mailbox stores one frame: an identifier, a flag that marks a standard or extended identifier, a data length code and eight data bytes. A mailbox is always in one of four states: empty, pending, scheduled or transmitting. Software writes the frame fields into an empty mailbox through a simple write port and then raises that mailbox's request line. From that point the frame is locked against host writes until the mailbox is empty again.

While no frame is on the wire, the scheduler re-ranks every waiting mailbox on each cycle. In identifier mode the lowest priority key wins, and the lower mailbox index breaks a tie. The key is 29 bits wide, with a standard 11-bit identifier shifted into its top bits. In queue mode, mailboxes leave in the order their requests arrived. The winner is marked scheduled, and it starts only when the bus is reported idle. At that point a one-cycle start pulse hands the frame to an external bit engine. The engine answers with done, lost (arbitration) or error. Each mailbox keeps four status flags: request complete, transmit OK, arbitration lost and transmit error. A write-one-to-clear line clears all four.

Top module: `can_tx_mailbox_sched`

## Requirements
- R1: Writes to a mailbox take effect only while it is empty. A request pulse on an empty mailbox makes it pending (mb_empty bit drops), and writes made after that are ignored, so the frame later sent is the one loaded before the request. Write select encoding: 0 = identifier (bits 28:0, bit 31 set means extended), 1 = DLC (bits 3:0), 2 = data bytes 0..3, 3 = data bytes 4..7.
- R2: A waiting mailbox becomes scheduled only when it is the top-ranked waiting mailbox. The ranking is redone each cycle while nothing transmits, so a newly requested mailbox with higher priority displaces a scheduled one that has not started.
- R3: A scheduled mailbox starts transmitting only in a cycle where bus_idle is high. No start pulse appears while bus_idle is low.
- R4: When the engine reports done, the mailbox becomes empty with request-complete and transmit-OK set.
- R5: A failure report sets arbitration-lost for lost and transmit-error for error. Both flags are set when both are reported together.
- R6: After a failure with cfg_auto_retx high, the mailbox goes back to waiting and is sent again. With cfg_auto_retx low, it becomes empty with request-complete set and transmit-OK clear.
- R7: With cfg_fifo_mode low, the mailbox with the smallest priority key goes first, and the lower index wins on equal keys. For an extended frame the key is the 29-bit identifier. For a standard frame it is the 11-bit identifier followed by 18 zero bits.
- R8: With cfg_fifo_mode high, mailboxes go out in the order their requests arrived, whatever their identifiers. Requests raised in the same cycle go lowest index first.
- R9: A pulse on a mailbox's host_clr bit clears its request-complete, transmit-OK, arbitration-lost and transmit-error flags.
- R10: At most one mailbox transmits at a time. eng_start is a single-cycle pulse at the start of a transmission, and eng_slot and the frame outputs hold steady until the engine answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_fifo_mode | input | 1 | 1 = request-order service, 0 = identifier priority |
| cfg_auto_retx | input | 1 | 1 = retry after a failed attempt |
| host_wr_en | input | 1 | Host field write strobe |
| host_wr_mb | input | 2 | Mailbox addressed by the write |
| host_wr_sel | input | 2 | Field select (see R1) |
| host_wr_data | input | 32 | Write data |
| host_req | input | 3 | Per-mailbox transmit request pulse |
| host_clr | input | 3 | Per-mailbox status clear pulse |
| mb_empty | output | 3 | Mailbox is empty |
| st_rqcp | output | 3 | Request-complete flags |
| st_txok | output | 3 | Transmit-OK flags |
| st_alst | output | 3 | Arbitration-lost flags |
| st_terr | output | 3 | Transmit-error flags |
| bus_idle | input | 1 | Engine reports the bus idle |
| eng_start | output | 1 | One-cycle start of a transmission |
| eng_slot | output | 2 | Mailbox being transmitted |
| eng_ide | output | 1 | Extended identifier flag of the frame |
| eng_id | output | 29 | Identifier of the frame |
| eng_dlc | output | 4 | Data length code of the frame |
| eng_data | output | 64 | Data bytes of the frame |
| eng_done | input | 1 | Engine reports success |
| eng_lost | input | 1 | Engine reports lost arbitration |
| eng_err | input | 1 | Engine reports a transmission error |

## Verification
Randomly filled mailbox sets are sent in identifier mode. Some identifiers are drawn from a tiny range, so equal keys and standard-against-extended comparisons happen often. This separates a correct key comparison and index tie-break from a plain identifier compare. The same mailbox sets with staggered or simultaneous request times are sent in queue mode, which shows whether request order really overrides the identifiers. Directed cases cover a late high-priority request displacing a scheduled mailbox, writes made during the locked window, a held-low bus_idle, a retry after lost arbitration, and a combined lost-and-error report with retry off. Each of these tells apart the paths for a successful and a failed completion.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

    localparam int ID_W   = 29;
    localparam int STD_W  = 11;
    localparam int DLC_W  = 4;
    localparam int HOST_W = 32;
    localparam int DATA_W = 2 * HOST_W;

    typedef enum logic [1:0] {
        MB_EMPTY = 2'd0,
        MB_PEND  = 2'd1,
        MB_SCHED = 2'd2,
        MB_XMIT  = 2'd3
    } mb_state_e;

    // host field select codes
    localparam logic [1:0] SEL_IDENT = 2'd0;
    localparam logic [1:0] SEL_CTRL  = 2'd1;
    localparam logic [1:0] SEL_DLO   = 2'd2;
    localparam logic [1:0] SEL_DHI   = 2'd3;

    typedef struct packed {
        logic              ide;
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic rqcp;
        logic txok;
        logic alst;
        logic terr;
    } flags_t;

    // Common 29-bit ranking scale: a standard identifier sits in the top bits.
    function automatic logic [ID_W-1:0] prio_key(input logic ide, input logic [ID_W-1:0] id);
        return ide ? id : {id[STD_W-1:0], {(ID_W-STD_W){1'b0}}};
    endfunction

endpackage

// File: rtl/txmb_arbiter.sv
module txmb_arbiter #(
    parameter int N     = 3,
    parameter int KEY_W = 29
) (
    input  logic                      fifo_mode,
    input  logic [N-1:0]              cand,
    input  logic [N-1:0][KEY_W-1:0]   keys,
    input  logic [N-1:0][N-1:0]       older,
    output logic [N-1:0]              win
);

    // older[j][i] = 1 means mailbox j raised its request before mailbox i
    for (genvar i = 0; i < N; i++) begin : g_cell
        logic beaten;
        always_comb begin
            beaten = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != i && cand[j]) begin
                    if (fifo_mode) begin
                        if (older[j][i]) beaten = 1'b1;
                    end else if ((keys[j] < keys[i]) || ((keys[j] == keys[i]) && (j < i))) begin
                        beaten = 1'b1;
                    end
                end
            end
        end
        assign win[i] = cand[i] & ~beaten;
    end

endmodule

// File: rtl/txmb_slot.sv
module txmb_slot
    import can_txmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [HOST_W-1:0] wr_data,
    input  logic              req,
    input  logic              clr,
    input  logic              auto_retx,
    input  logic              win,
    input  logic              any_tx,
    input  logic              bus_idle,
    input  logic              eng_done,
    input  logic              eng_lost,
    input  logic              eng_err,
    output mb_state_e         state,
    output frame_t            frame,
    output flags_t            flags,
    output logic              accept,
    output logic              launch,
    output logic              in_tx
);

    typedef struct packed {
        mb_state_e st;
        frame_t    fr;
        flags_t    fl;
    } slot_regs_t;

    slot_regs_t slot_q, slot_d;

    always_comb begin
        slot_d = slot_q;
        accept = 1'b0;

        if (wr_en && slot_q.st == MB_EMPTY) begin
            unique case (wr_sel)
                SEL_IDENT: begin
                    slot_d.fr.id  = wr_data[ID_W-1:0];
                    slot_d.fr.ide = wr_data[HOST_W-1];
                end
                SEL_CTRL:  slot_d.fr.dlc = wr_data[DLC_W-1:0];
                SEL_DLO:   slot_d.fr.data[HOST_W-1:0] = wr_data;
                SEL_DHI:   slot_d.fr.data[DATA_W-1:HOST_W] = wr_data;
            endcase
        end

        if (clr) slot_d.fl = '0;

        unique case (slot_q.st)
            MB_EMPTY: begin
                if (req) begin
                    slot_d.st = MB_PEND;
                    accept    = 1'b1;
                end
            end
            MB_PEND: begin
                if (!any_tx && win) slot_d.st = MB_SCHED;
            end
            MB_SCHED: begin
                if (!any_tx) begin
                    if (!win)          slot_d.st = MB_PEND;
                    else if (bus_idle) slot_d.st = MB_XMIT;
                end
            end
            MB_XMIT: begin
                if (eng_done) begin
                    slot_d.st      = MB_EMPTY;
                    slot_d.fl.rqcp = 1'b1;
                    slot_d.fl.txok = 1'b1;
                end else if (eng_lost || eng_err) begin
                    slot_d.fl.alst = slot_d.fl.alst | eng_lost;
                    slot_d.fl.terr = slot_d.fl.terr | eng_err;
                    if (auto_retx) begin
                        slot_d.st = MB_PEND;
                    end else begin
                        slot_d.st      = MB_EMPTY;
                        slot_d.fl.rqcp = 1'b1;
                        slot_d.fl.txok = 1'b0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign state  = slot_q.st;
    assign frame  = slot_q.fr;
    assign flags  = slot_q.fl;
    assign in_tx  = (slot_q.st == MB_XMIT);
    assign launch = (slot_q.st != MB_XMIT) && (slot_d.st == MB_XMIT);

    // R1: frame contents frozen while the mailbox is occupied
    assert_locked_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.st != MB_EMPTY) |=> $stable(slot_q.fr));

    // R2: a mailbox is scheduled only after winning the ranking
    assert_sched_after_win_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_q.st == MB_SCHED) && ($past(slot_q.st) == MB_PEND)) |-> $past(win));

    // R3: transmission starts from scheduled and only on an idle bus
    assert_start_on_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_q.st == MB_XMIT) && ($past(slot_q.st) != MB_XMIT))
            |-> ($past(bus_idle) && ($past(slot_q.st) == MB_SCHED)));

    // R4: success empties the mailbox with both completion flags
    assert_success_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_q.st == MB_XMIT) && eng_done)
            |=> ((slot_q.st == MB_EMPTY) && slot_q.fl.rqcp && slot_q.fl.txok));

    // R6: failure without retry empties with complete set and OK clear
    assert_fail_no_retry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_q.st == MB_XMIT) && !eng_done && (eng_lost || eng_err) && !auto_retx)
            |=> ((slot_q.st == MB_EMPTY) && slot_q.fl.rqcp && !slot_q.fl.txok));

    // R9: a clear outside transmission drops the complete flag
    assert_clear_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (slot_q.st != MB_XMIT)) |=> !slot_q.fl.rqcp);

endmodule

// File: rtl/can_tx_mailbox_sched.sv
module can_tx_mailbox_sched
    import can_txmb_pkg::*;
#(
    parameter int NUM_MB = 3,
    localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fifo_mode,
    input  logic              cfg_auto_retx,
    input  logic              host_wr_en,
    input  logic [IDX_W-1:0]  host_wr_mb,
    input  logic [1:0]        host_wr_sel,
    input  logic [HOST_W-1:0] host_wr_data,
    input  logic [NUM_MB-1:0] host_req,
    input  logic [NUM_MB-1:0] host_clr,
    output logic [NUM_MB-1:0] mb_empty,
    output logic [NUM_MB-1:0] st_rqcp,
    output logic [NUM_MB-1:0] st_txok,
    output logic [NUM_MB-1:0] st_alst,
    output logic [NUM_MB-1:0] st_terr,
    input  logic              bus_idle,
    output logic              eng_start,
    output logic [IDX_W-1:0]  eng_slot,
    output logic              eng_ide,
    output logic [ID_W-1:0]   eng_id,
    output logic [DLC_W-1:0]  eng_dlc,
    output logic [DATA_W-1:0] eng_data,
    input  logic              eng_done,
    input  logic              eng_lost,
    input  logic              eng_err
);

    typedef struct packed {
        logic                          start;
        logic [NUM_MB-1:0][NUM_MB-1:0] older;
    } top_regs_t;

    top_regs_t top_q, top_d;

    mb_state_e                    slot_st [NUM_MB];
    frame_t                       slot_fr [NUM_MB];
    flags_t                       slot_fl [NUM_MB];
    logic [NUM_MB-1:0]            accepted, launch, in_tx, cand, win;
    logic [NUM_MB-1:0][ID_W-1:0]  keys;
    logic                         any_tx;
    frame_t                       tx_frame;
    logic [IDX_W-1:0]             tx_slot;

    assign any_tx = |in_tx;

    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        txmb_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (host_wr_en && (host_wr_mb == IDX_W'(i))),
            .wr_sel    (host_wr_sel),
            .wr_data   (host_wr_data),
            .req       (host_req[i]),
            .clr       (host_clr[i]),
            .auto_retx (cfg_auto_retx),
            .win       (win[i]),
            .any_tx    (any_tx),
            .bus_idle  (bus_idle),
            .eng_done  (eng_done),
            .eng_lost  (eng_lost),
            .eng_err   (eng_err),
            .state     (slot_st[i]),
            .frame     (slot_fr[i]),
            .flags     (slot_fl[i]),
            .accept    (accepted[i]),
            .launch    (launch[i]),
            .in_tx     (in_tx[i])
        );

        assign cand[i]     = (slot_st[i] == MB_PEND) || (slot_st[i] == MB_SCHED);
        assign keys[i]     = prio_key(slot_fr[i].ide, slot_fr[i].id);
        assign mb_empty[i] = (slot_st[i] == MB_EMPTY);
        assign st_rqcp[i]  = slot_fl[i].rqcp;
        assign st_txok[i]  = slot_fl[i].txok;
        assign st_alst[i]  = slot_fl[i].alst;
        assign st_terr[i]  = slot_fl[i].terr;
    end

    txmb_arbiter #(
        .N     (NUM_MB),
        .KEY_W (ID_W)
    ) u_arb (
        .fifo_mode (cfg_fifo_mode),
        .cand      (cand),
        .keys      (keys),
        .older     (top_q.older),
        .win       (win)
    );

    // next-state: start pulse and request-age matrix
    always_comb begin
        top_d       = top_q;
        top_d.start = |launch;
        for (int i = 0; i < NUM_MB; i++) begin
            for (int j = 0; j < NUM_MB; j++) begin
                if (i != j) begin
                    if (accepted[i] && accepted[j]) top_d.older[i][j] = (i < j);
                    else if (accepted[j])           top_d.older[i][j] = 1'b1;
                    else if (accepted[i])           top_d.older[i][j] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    always_comb begin
        tx_frame = '0;
        tx_slot  = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (in_tx[i]) begin
                tx_frame = slot_fr[i];
                tx_slot  = IDX_W'(i);
            end
        end
    end

    assign eng_start = top_q.start;
    assign eng_slot  = tx_slot;
    assign eng_ide   = tx_frame.ide;
    assign eng_id    = tx_frame.id;
    assign eng_dlc   = tx_frame.dlc;
    assign eng_data  = tx_frame.data;

    // R2: the ranking never names two winners, and names one when any wait
    assert_single_winner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win));
    assert_winner_exists_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|cand) |-> (|win));

    // R10: one transmission at a time, start is a pulse inside it
    assert_one_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_tx) <= 1);
    assert_start_in_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (|in_tx));
    assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    assert_frame_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|in_tx) && $past(|in_tx) && !$past(eng_done || eng_lost || eng_err))
            |-> ($stable(eng_id) && $stable(eng_slot) && $stable(eng_data)));

endmodule

// File: tb/can_tx_mailbox_sched_bench.sv
`timescale 1ns/1ps
module can_tx_mailbox_sched_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fifo_mode = 1'b0, cfg_auto_retx = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [1:0]  host_wr_mb = '0, host_wr_sel = '0;
    logic [31:0] host_wr_data = '0;
    logic [2:0]  host_req = '0, host_clr = '0;
    logic [2:0]  mb_empty, st_rqcp, st_txok, st_alst, st_terr;
    logic        bus_idle = 1'b0;
    logic        eng_start, eng_ide;
    logic [1:0]  eng_slot;
    logic [28:0] eng_id;
    logic [3:0]  eng_dlc;
    logic [63:0] eng_data;
    logic        eng_done = 1'b0, eng_lost = 1'b0, eng_err = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    can_tx_mailbox_sched u_can_tx_mailbox_sched (
        .clk(clk), .rst_n(rst_n), .cfg_fifo_mode(cfg_fifo_mode), .cfg_auto_retx(cfg_auto_retx),
        .host_wr_en(host_wr_en), .host_wr_mb(host_wr_mb), .host_wr_sel(host_wr_sel),
        .host_wr_data(host_wr_data), .host_req(host_req), .host_clr(host_clr),
        .mb_empty(mb_empty), .st_rqcp(st_rqcp), .st_txok(st_txok), .st_alst(st_alst),
        .st_terr(st_terr), .bus_idle(bus_idle), .eng_start(eng_start), .eng_slot(eng_slot),
        .eng_ide(eng_ide), .eng_id(eng_id), .eng_dlc(eng_dlc), .eng_data(eng_data),
        .eng_done(eng_done), .eng_lost(eng_lost), .eng_err(eng_err)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [28:0] bkey(input logic ide, input logic [28:0] id);
        return ide ? id : {id[10:0], 18'd0};
    endfunction

    function automatic bit ahead(input int a, input int b, input bit fifo,
                                 input logic [28:0] k[3], input int t[3]);
        if (fifo) return (t[a] < t[b]) || (t[a] == t[b] && a < b);
        return (k[a] < k[b]) || (k[a] == k[b] && a < b);
    endfunction

    task automatic write_field(input int mb, input logic [1:0] sel, input logic [31:0] data);
        host_wr_en = 1'b1; host_wr_mb = 2'(mb); host_wr_sel = sel; host_wr_data = data;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic load(input int mb, input logic ide, input logic [28:0] id);
        write_field(mb, 2'd0, {ide, 2'b00, id});
        write_field(mb, 2'd1, 32'(mb + 5));
        write_field(mb, 2'd2, $urandom);
        write_field(mb, 2'd3, $urandom);
    endtask

    task automatic request(input logic [2:0] mask);
        host_req = mask;
        @(negedge clk);
        host_req = '0;
    endtask

    task automatic clear_all();
        host_clr = 3'b111;
        @(negedge clk);
        host_clr = '0;
    endtask

    task automatic wait_start(output int slot, output logic [28:0] id, output bit got);
        got = 1'b0; slot = -1; id = '0;
        for (int k = 0; k < 40 && !got; k++) begin
            if (eng_start === 1'b1) begin
                got = 1'b1; slot = int'(eng_slot); id = eng_id;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    // kind: 0 done, 1 lost, 2 error, 3 lost and error
    task automatic engine_end(input int kind);
        logic [1:0] s0;
        s0 = eng_slot;
        @(negedge clk);
        check("R10 start is a single pulse", eng_start, 0);
        check("R10 slot steady while sending", eng_slot, s0);
        @(negedge clk);
        eng_done = (kind == 0);
        eng_lost = (kind == 1 || kind == 3);
        eng_err  = (kind == 2 || kind == 3);
        @(negedge clk);
        eng_done = 1'b0; eng_lost = 1'b0; eng_err = 1'b0;
    endtask

    task automatic run_trial(input bit fifo);
        logic [28:0] k[3];
        logic [28:0] ids[3];
        int          t[3];
        int          ord[3];
        bit          used[3];
        int          slot;
        logic [28:0] got_id;
        bit          got;
        cfg_fifo_mode = fifo;
        bus_idle = 1'b0;
        for (int m = 0; m < 3; m++) begin
            logic ide;
            logic [28:0] id;
            ide = 1'($urandom % 2);
            id  = ($urandom % 3 == 0) ? 29'($urandom % 4) : 29'($urandom);
            if (!ide) id = {18'd0, id[10:0]};
            ids[m] = id;
            k[m] = bkey(ide, id);
            t[m] = int'($urandom % 3);
            load(m, ide, id);
        end
        for (int c = 0; c < 3; c++) begin
            logic [2:0] mask;
            mask = '0;
            for (int m = 0; m < 3; m++) if (t[m] == c) mask[m] = 1'b1;
            request(mask);
        end
        for (int m = 0; m < 3; m++) used[m] = 1'b0;
        for (int p = 0; p < 3; p++) begin
            int best;
            best = -1;
            for (int m = 0; m < 3; m++)
                if (!used[m] && (best < 0 || ahead(m, best, fifo, k, t))) best = m;
            ord[p] = best;
            used[best] = 1'b1;
        end
        bus_idle = 1'b1;
        for (int p = 0; p < 3; p++) begin
            wait_start(slot, got_id, got);
            check("R3 start seen on idle bus", got, 1);
            if (fifo) check("R8 request-order slot", slot, ord[p]);
            else      check("R7 key-order slot", slot, ord[p]);
            if (got) check("R1 sent identifier", got_id, ids[ord[p]]);
            engine_end(0);
        end
        check("R4 all mailboxes empty after trial", mb_empty, 3'b111);
        clear_all();
    endtask

    initial begin
        int          slot;
        logic [28:0] got_id;
        bit          got;
        int          starts;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        check("R1 reset empty", mb_empty, 3'b111);
        check("R4 reset flags", {st_rqcp, st_txok, st_alst, st_terr}, 12'h000);
        check("R10 reset no start", eng_start, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // locked writes, idle gating, success, clear
        load(0, 1'b0, 29'h123);
        request(3'b001);
        check("R1 request makes mailbox pending", mb_empty, 3'b110);
        write_field(0, 2'd0, 32'h0000_07FF);
        starts = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (eng_start) starts++;
        end
        check("R3 no start while bus busy", starts, 0);
        bus_idle = 1'b1;
        wait_start(slot, got_id, got);
        check("R1 locked write ignored", got_id, 29'h123);
        engine_end(0);
        check("R4 empty after success", mb_empty[0], 1);
        check("R4 complete flag", st_rqcp[0], 1);
        check("R4 ok flag", st_txok[0], 1);
        host_clr = 3'b001;
        @(negedge clk);
        host_clr = '0;
        check("R9 flags cleared", {st_rqcp[0], st_txok[0], st_alst[0], st_terr[0]}, 0);

        // retry after lost arbitration
        cfg_auto_retx = 1'b1;
        load(1, 1'b1, 29'h0ABCDEF);
        request(3'b010);
        wait_start(slot, got_id, got);
        check("R6 first attempt slot", slot, 1);
        engine_end(1);
        check("R5 lost flag", st_alst[1], 1);
        check("R6 retry keeps mailbox busy", mb_empty[1], 0);
        check("R6 no completion yet", st_rqcp[1], 0);
        wait_start(slot, got_id, got);
        check("R6 retransmitted", got && slot == 1, 1);
        engine_end(0);
        check("R6 ok after retry", {st_rqcp[1], st_txok[1], st_alst[1]}, 3'b111);

        // no retry, lost and error together
        cfg_auto_retx = 1'b0;
        load(2, 1'b0, 29'h055);
        request(3'b100);
        wait_start(slot, got_id, got);
        engine_end(3);
        check("R5 both failure flags", {st_alst[2], st_terr[2]}, 2'b11);
        check("R6 complete set, ok clear", {st_rqcp[2], st_txok[2]}, 2'b10);
        check("R6 empty without retry", mb_empty[2], 1);
        clear_all();
        check("R9 all flags cleared", {st_rqcp, st_txok, st_alst, st_terr}, 12'h000);

        // displacement of a scheduled mailbox
        bus_idle = 1'b0;
        load(2, 1'b0, 29'h100);
        load(1, 1'b0, 29'h050);
        request(3'b100);
        repeat (3) @(negedge clk);
        request(3'b010);
        @(negedge clk);
        bus_idle = 1'b1;
        wait_start(slot, got_id, got);
        check("R2 late higher priority displaces", slot, 1);
        engine_end(0);
        wait_start(slot, got_id, got);
        check("R2 displaced mailbox follows", slot, 2);
        engine_end(0);
        clear_all();

        // standard vs extended scale, equal key tie
        bus_idle = 1'b0;
        cfg_fifo_mode = 1'b0;
        load(0, 1'b0, 29'h001);
        load(1, 1'b1, 29'h0000010);
        load(2, 1'b1, 29'h0040000);
        request(3'b111);
        bus_idle = 1'b1;
        for (int p = 0; p < 3; p++) begin
            int exp_slot;
            exp_slot = (p == 0) ? 1 : (p == 1) ? 0 : 2;
            wait_start(slot, got_id, got);
            check("R7 aligned key order", slot, exp_slot);
            engine_end(0);
        end
        clear_all();

        for (int n = 0; n < 20; n++) run_trial(1'b0);
        for (int n = 0; n < 20; n++) run_trial(1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule